// File: doc/BRIEF.md
# Stepped-Voltage Program-Verify Sequencer

This block drives a resistive memory cell into a conductance window by issuing programming pulses whose voltage code steps after every pulse. After an initial reset pulse it runs two loops one after the other: set pulses with a rising voltage code until the cell reaches the lower conductance bound, then reset pulses with a falling code while the cell sits above the upper bound. Every pulse is followed by a conductance read, and that reading decides the next step.

Pulse shaping and sensing are done elsewhere. The sequencer hands the pulse generator a voltage code, a polarity, and three durations in clock cycles (rise, flat top, fall). It also gives a flag that selects the slow fall used by set pulses. It then waits out the pulse and requests a read. When both loops have finished, it reports completion, whether the last reading lies inside the window, and the code it ended on.

Top module: `stepv_prog_ctrl`

## Requirements
- R1: When idle, `start` latches `g_lo`, `g_hi`, `v_init`, `v_max` and `v_step`, loads the working code with `v_init` and issues one reset pulse (`pulse_kind`=1) at code `v_max`. Input changes and further `start` pulses during a run have no effect on that run.
- R2: Set loop: while the working code is below the latched `v_max` and the last reading is below `g_lo`, a set pulse (`pulse_kind`=0) is issued at the working code, and the code then grows by the step. The reading taken after the initial reset is the first one tested.
- R3: Reset loop: it runs after the set loop exits, never before it. While the working code is below `v_max` and the last reading is above `g_hi`, a reset pulse is issued at the working code, and the code then shrinks by the step. A reset pulse issued at code 0 ends the loop. No set pulse follows a loop reset pulse.
- R4: Code arithmetic saturates at 0 and at the code maximum (63 with 6-bit codes) and never wraps. A latched step of 0 is treated as a step of 1.
- R5: During a pulse request, `rise_cyc`=2 and `on_cyc`=30 (10 ns clock). Set pulses carry `fall_cyc`=150 with `slow_fall`=1. Reset pulses carry `fall_cyc`=2 with `slow_fall`=0.
- R6: `pulse_req` and `read_req` are single-cycle strobes and are never high together. `read_req` rises exactly rise+on+fall+1 cycles after `pulse_req`. The next decision waits for `rd_valid`.
- R7: When both loops have exited, `done` rises and holds until the next accepted `start`. `v_final` is the working code at that time. `in_win` is 1 exactly when `g_lo` ≤ last reading ≤ `g_hi`. No request is issued while `done` is high.
- R8: After reset, `pulse_req`, `read_req`, `done`, `in_win` and `v_final` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| g_lo | input | GW | Lower conductance bound |
| g_hi | input | GW | Upper conductance bound |
| v_init | input | VW | Starting voltage code of the loops |
| v_max | input | VW | Voltage ceiling shared by both loops; also the code of the initial reset |
| v_step | input | VW | Code increment and decrement |
| rd_data | input | GW | Digitized conductance reading |
| rd_valid | input | 1 | Reading valid strobe |
| pulse_req | output | 1 | One-cycle pulse request |
| pulse_kind | output | 1 | 0 = set, 1 = reset |
| pulse_v | output | VW | Voltage code of the requested pulse |
| slow_fall | output | 1 | Slow trailing edge selected |
| rise_cyc | output | DW | Rise duration in cycles |
| on_cyc | output | DW | Flat-top duration in cycles |
| fall_cyc | output | DW | Fall duration in cycles |
| read_req | output | 1 | One-cycle read request |
| done | output | 1 | Run finished (level) |
| in_win | output | 1 | Last reading within [g_lo, g_hi] |
| v_final | output | VW | Working code at completion |

## Verification
A pulse request appears on the second clock after an accepted `start` and on the second clock after each accepted `rd_valid` that continues a loop. The read request follows exactly 183 cycles after a set pulse and 35 cycles after a reset pulse. The bench acts as the cell: it answers each read two cycles after the request. It samples every strobe on the falling edge of the cycle in which it is high and checks each pulse's polarity, code and durations against a list computed beforehand by an arithmetic model of the two loops. `done`, `in_win` and `v_final` are compared once `done` is seen. The falling edge after `start` is skipped, because the previous run's `done` only clears on that edge.

// File: rtl/stepv_prog_ctrl.sv
module stepv_prog_ctrl #(
  parameter int VW = 6,
  parameter int GW = 8,
  parameter int CLK_NS = 10,
  parameter int RISE_NS = 20,
  parameter int WIDTH_NS = 300,
  parameter int SFALL_NS = 1500,
  parameter int FFALL_NS = 20,
  localparam int RISE_C = (RISE_NS + CLK_NS - 1) / CLK_NS,
  localparam int WID_C = (WIDTH_NS + CLK_NS - 1) / CLK_NS,
  localparam int SFALL_C = (SFALL_NS + CLK_NS - 1) / CLK_NS,
  localparam int FFALL_C = (FFALL_NS + CLK_NS - 1) / CLK_NS,
  localparam int TOT_MAX = RISE_C + WID_C + ((SFALL_C > FFALL_C) ? SFALL_C : FFALL_C),
  localparam int DW = $clog2(TOT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [GW-1:0] g_lo,
  input  logic [GW-1:0] g_hi,
  input  logic [VW-1:0] v_init,
  input  logic [VW-1:0] v_max,
  input  logic [VW-1:0] v_step,
  input  logic [GW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          pulse_req,
  output logic          pulse_kind,
  output logic [VW-1:0] pulse_v,
  output logic          slow_fall,
  output logic [DW-1:0] rise_cyc,
  output logic [DW-1:0] on_cyc,
  output logic [DW-1:0] fall_cyc,
  output logic          read_req,
  output logic          done,
  output logic          in_win,
  output logic [VW-1:0] v_final
);
  localparam int CODE_MAX = (1 << VW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_WAIT, S_READ, S_RWAIT, S_EVAL} state_t;
  typedef enum logic [1:0] {P_INIT, P_SET, P_RST} phase_t;

  state_t state;
  phase_t phase;
  logic [GW-1:0] glo_q, ghi_q, g_q;
  logic [VW-1:0] vmax_q, step_q, v_q;
  logic [DW-1:0] cnt;
  logic kind, floor_hit;

  logic [VW:0]   v_sum;
  logic [VW-1:0] v_up, v_dn;
  logic set_go, rst_go;

  assign v_sum  = {1'b0, v_q} + {1'b0, step_q};
  assign v_up   = (v_sum > CODE_MAX) ? VW'(CODE_MAX) : v_sum[VW-1:0];
  assign v_dn   = (v_q > step_q) ? v_q - step_q : '0;
  assign set_go = (v_q < vmax_q) && (g_q < glo_q);
  assign rst_go = !floor_hit && (v_q < vmax_q) && (g_q > ghi_q);

  assign pulse_req  = (state == S_PULSE);
  assign read_req   = (state == S_READ);
  assign pulse_kind = kind;
  assign pulse_v    = (phase == P_INIT) ? vmax_q : v_q;
  assign slow_fall  = ~kind;
  assign rise_cyc   = DW'(RISE_C);
  assign on_cyc     = DW'(WID_C);
  assign fall_cyc   = kind ? DW'(FFALL_C) : DW'(SFALL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= P_INIT;
      glo_q <= '0;
      ghi_q <= '0;
      g_q <= '0;
      vmax_q <= '0;
      step_q <= '0;
      v_q <= '0;
      cnt <= '0;
      kind <= 1'b1;
      floor_hit <= 1'b0;
      done <= 1'b0;
      in_win <= 1'b0;
      v_final <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          glo_q <= g_lo;
          ghi_q <= g_hi;
          vmax_q <= v_max;
          step_q <= (v_step == '0) ? VW'(1) : v_step;
          v_q <= v_init;
          phase <= P_INIT;
          kind <= 1'b1;
          floor_hit <= 1'b0;
          done <= 1'b0;
          in_win <= 1'b0;
          state <= S_PULSE;
        end
        S_PULSE: begin
          cnt <= rise_cyc + on_cyc + fall_cyc;
          state <= S_WAIT;
          if (phase != P_INIT) begin
            if (!kind) v_q <= v_up;
            else begin
              v_q <= v_dn;
              floor_hit <= (v_q == '0);
            end
          end
        end
        S_WAIT: begin
          if (cnt == DW'(1)) state <= S_READ;
          else cnt <= cnt - 1'b1;
        end
        S_READ: state <= S_RWAIT;
        S_RWAIT: if (rd_valid) begin
          g_q <= rd_data;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (phase != P_RST && set_go) begin
            phase <= P_SET;
            kind <= 1'b0;
            state <= S_PULSE;
          end else if (rst_go) begin
            phase <= P_RST;
            kind <= 1'b1;
            state <= S_PULSE;
          end else begin
            done <= 1'b1;
            in_win <= (g_q >= glo_q) && (g_q <= ghi_q);
            v_final <= v_q;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stepv_prog_ctrl_chk.sv
module stepv_prog_ctrl_chk #(
  parameter int VW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pulse_req,
  input logic          pulse_kind,
  input logic [VW-1:0] pulse_v,
  input logic [DW-1:0] rise_cyc,
  input logic [DW-1:0] on_cyc,
  input logic [DW-1:0] fall_cyc,
  input logic          read_req,
  input logic          done
);
  logic [DW+1:0] gap, exp_gap;
  logic seen_first, have_set, have_rst;
  logic [VW-1:0] last_set, last_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
      exp_gap <= '0;
      seen_first <= 1'b0;
      have_set <= 1'b0;
      have_rst <= 1'b0;
      last_set <= '0;
      last_rst <= '0;
    end else begin
      if (pulse_req) begin
        gap <= (DW+2)'(1);
        exp_gap <= (DW+2)'(rise_cyc) + (DW+2)'(on_cyc) + (DW+2)'(fall_cyc) + (DW+2)'(1);
      end else if (gap != '1) gap <= gap + 1'b1;
      if (done) begin
        seen_first <= 1'b0;
        have_set <= 1'b0;
        have_rst <= 1'b0;
      end else if (pulse_req) begin
        seen_first <= 1'b1;
        if (!pulse_kind) begin
          have_set <= 1'b1;
          last_set <= pulse_v;
        end else if (seen_first) begin
          have_rst <= 1'b1;
          last_rst <= pulse_v;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(pulse_req && read_req)); // R6
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n) read_req |-> gap == exp_gap); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> !pulse_req && !read_req); // R7
  AST_SET_RISES: assert property (@(posedge clk) disable iff (!rst_n) (pulse_req && !pulse_kind && have_set) |-> pulse_v > last_set); // R2
  AST_RST_FALLS: assert property (@(posedge clk) disable iff (!rst_n) (pulse_req && pulse_kind && have_rst) |-> pulse_v < last_rst); // R3
  AST_NO_SET_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n) (pulse_req && have_rst) |-> pulse_kind); // R3
endmodule

bind stepv_prog_ctrl stepv_prog_ctrl_chk #(.VW(VW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_req(pulse_req), .pulse_kind(pulse_kind),
  .pulse_v(pulse_v), .rise_cyc(rise_cyc), .on_cyc(on_cyc), .fall_cyc(fall_cyc),
  .read_req(read_req), .done(done)
);

// File: tb/stepv_prog_ctrl_test.sv
module stepv_prog_ctrl_test;
  localparam int PERIOD = 10;
  localparam int VW = 6;
  localparam int GW = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_valid = 1'b0;
  logic [GW-1:0] g_lo = '0, g_hi = '0, rd_data = '0;
  logic [VW-1:0] v_init = '0, v_max = '0, v_step = '0;
  logic pulse_req, pulse_kind, slow_fall, read_req, done, in_win;
  logic [VW-1:0] pulse_v, v_final;
  logic [DW-1:0] rise_cyc, on_cyc, fall_cyc;

  stepv_prog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .g_lo(g_lo), .g_hi(g_hi),
    .v_init(v_init), .v_max(v_max), .v_step(v_step), .rd_data(rd_data), .rd_valid(rd_valid),
    .pulse_req(pulse_req), .pulse_kind(pulse_kind), .pulse_v(pulse_v), .slow_fall(slow_fall),
    .rise_cyc(rise_cyc), .on_cyc(on_cyc), .fall_cyc(fall_cyc), .read_req(read_req),
    .done(done), .in_win(in_win), .v_final(v_final)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int exp_kind [256];
  int exp_v [256];
  int exp_n, exp_vf, exp_win, seen_n, gap, last_kind, rd_cnt;
  int g_cell;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cset(input int g, input int v);
    return (g + v > 255) ? 255 : g + v;
  endfunction
  function automatic int crst(input int g, input int v);
    return (g > v) ? g - v : 0;
  endfunction

  task automatic build_ref(input int g0, input int lo, input int hi, input int vi, input int vm, input int st);
    int g, v, s, fl;
    exp_n = 0;
    g = crst(g0, vm);
    exp_kind[exp_n] = 1; exp_v[exp_n] = vm; exp_n++;
    v = vi;
    s = (st == 0) ? 1 : st;
    while (v < vm && g < lo) begin
      exp_kind[exp_n] = 0; exp_v[exp_n] = v; exp_n++;
      g = cset(g, v);
      v = (v + s > 63) ? 63 : v + s;
    end
    fl = 0;
    while (!fl && v < vm && g > hi) begin
      exp_kind[exp_n] = 1; exp_v[exp_n] = v; exp_n++;
      g = crst(g, v);
      fl = (v == 0);
      v = (v > s) ? v - s : 0;
    end
    exp_vf = v;
    exp_win = (g >= lo && g <= hi) ? 1 : 0;
  endtask

  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        rd_valid = 1'b1;
        rd_data = GW'(g_cell);
      end
    end
    if (pulse_req) begin
      gap = 0;
      last_kind = pulse_kind;
      if (seen_n < exp_n) begin
        chk(pulse_kind == exp_kind[seen_n][0], "R1/R2/R3 kind", pulse_kind, exp_kind[seen_n]);
        chk(pulse_v == exp_v[seen_n], "R2/R3/R4 code", pulse_v, exp_v[seen_n]);
      end else chk(0, "R2/R3 extra pulse", seen_n, exp_n);
      chk(rise_cyc == 2 && on_cyc == 30, "R5 rise/on", rise_cyc * 1000 + on_cyc, 2030);
      chk(fall_cyc == (pulse_kind ? 2 : 150), "R5 fall", fall_cyc, pulse_kind ? 2 : 150);
      chk(slow_fall == !pulse_kind, "R5 slow_fall", slow_fall, !pulse_kind);
      g_cell = pulse_kind ? crst(g_cell, pulse_v) : cset(g_cell, pulse_v);
      seen_n++;
    end else gap++;
    if (read_req) begin
      chk(gap == (last_kind ? 35 : 183), "R6 read gap", gap, last_kind ? 35 : 183);
      chk(!pulse_req, "R6 strobes overlap", pulse_req, 0);
      rd_cnt = 2;
    end
  end

  task automatic run_case(input int g0, input int lo, input int hi, input int vi, input int vm, input int st, input bit poke);
    int t;
    build_ref(g0, lo, hi, vi, vm, st);
    g_cell = g0;
    seen_n = 0;
    @(negedge clk);
    g_lo = GW'(lo); g_hi = GW'(hi); v_init = VW'(vi); v_max = VW'(vm); v_step = VW'(st);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (poke) begin
      repeat (100) @(negedge clk);
      g_lo = '0; g_hi = '0; v_init = '0; v_max = '0; v_step = 6'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R7 done", done, 1);
    chk(seen_n == exp_n, "R2/R3 pulse count", seen_n, exp_n);
    chk(v_final == exp_vf, "R4/R7 v_final", v_final, exp_vf);
    chk(in_win == exp_win[0], "R7 in_win", in_win, exp_win);
    repeat (5) @(negedge clk);
    chk(done && seen_n == exp_n, "R7 done holds, no requests", seen_n, exp_n);
  endtask

  initial begin
    #(200000 * PERIOD);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rd_cnt = 0; gap = 0; last_kind = 0; exp_n = 0; seen_n = 0; g_cell = 0;
    repeat (3) @(negedge clk);
    chk(!pulse_req && !read_req && !done && !in_win && v_final == 0, "R8 reset state",
        {pulse_req, read_req, done, in_win}, 0);
    rst_n = 1'b1;
    run_case(200, 100, 150, 4, 40, 4, 0);  // R3 floor exit
    run_case(50, 120, 140, 5, 60, 5, 1);   // R1 inputs and start ignored mid-run
    run_case(0, 200, 210, 10, 63, 13, 0);  // R4 ceiling saturation
    run_case(0, 10, 20, 2, 8, 0, 0);       // R4 zero step
    run_case(0, 50, 60, 30, 60, 10, 0);    // R2 then R3
    run_case(255, 10, 250, 63, 63, 1, 0);  // R7 no loops
    run_case(5, 9, 9, 0, 3, 2, 0);
    for (int st = 1; st <= 6; st++) run_case(0, 100, 130, 3, 50, st, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule